// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block sits beside an SDRAM controller and watches the command stream it issues. Each cycle may carry one command (row activate, column read, column write, precharge, auto refresh or burst stop), a target bank, and, independently, a marker that the last write data beat is on the bus. For each command the checker decides whether a spacing rule or a bank-state rule is broken. It reports the broken rule as a one-cycle pulse with a numeric code. It also keeps the code and the cycle number of the first failure since reset.

Every limit is given at elaboration as a time in picoseconds, together with the clock period. The block turns each limit into a cycle count and keeps per-bank saturating age counters, so no wide timestamps are compared. Beyond the minimum spacings, it flags a row that has stayed open longer than the maximum active time. It also checks write recovery counted from the last data-in beat. It does not drive memory pins, model data or look at mode-register contents.

Top module: `sdtm_mon`

## Requirements
- R1: Each nanosecond limit becomes a cycle count equal to the limit divided by the clock period, rounded up. At the defaults (10 ns clock) the counts are: bank-to-bank activate 2, activate to column 2, precharge to activate 2, minimum active 4, same-bank activate cycle 6, refresh cycle 6. A same-bank activate 5 cycles after the previous one is flagged.
- R2: `cmd_op` encoding: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 burst stop, 7 reserved. Commands count only while `cmd_valid` is high. Idle and reserved never raise a violation and change no bank state.
- R3: A violation found in cycle t shows as `viol_o` high for exactly the following cycle, with `viol_code_o` holding the code. Codes: 0 none, 1 activate to open bank, 2 column or precharge to closed bank, 3 refresh with a bank open, 4 bank-to-bank activate, 5 activate to column, 6 precharge to activate or refresh, 7 minimum active time, 8 maximum active time, 9 same-bank activate cycle, 10 refresh cycle, 11 write data to column, 12 write data to precharge, 13 write data to burst stop. When several rules fail at once, the lowest code is reported.
- R4: An activate to a bank with an open row gives code 1. A read, write or precharge to a bank with no open row gives code 2.
- R5: An auto refresh while any bank is open gives code 3.
- R6: An activate fewer than the bank-to-bank count of cycles after the previous activate to any bank gives code 4. An activate fewer than the activate-cycle count after the previous activate to the same bank gives code 9.
- R7: A read or write fewer than the activate-to-column count of cycles after its bank's activate gives code 5.
- R8: An activate, or an auto refresh, that comes fewer than the precharge count of cycles after a precharge of the bank concerned (for a refresh, of any bank) gives code 6.
- R9: A precharge fewer than the minimum-active count of cycles after its bank's activate gives code 7.
- R10: A row open for more than the maximum-active count M of cycles gives one code 8 pulse, seen M+2 cycles after the activate cycle, whether or not a command is present.
- R11: Any command fewer than the refresh-cycle count of cycles after an auto refresh gives code 10.
- R12: With `wr_last_beat` high in cycle w, the following are flagged. A read or write at w, fewer than 1 cycle later, gives code 11. A precharge before w+2 gives code 12. A burst stop at w gives code 13.
- R13: On the first violation after reset, `first_valid_o` rises, `first_code_o` takes its code and `first_cycle_o` takes the number of its cycle. The cycle count is 0 in the first cycle after reset is released. All three hold until the next reset.
- R14: During and after reset all outputs are zero, every bank counts as closed, and every spacing counter behaves as if a long time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | BW = log2(NUM_BANKS) | Target bank |
| wr_last_beat | input | 1 | Last write data beat on the bus this cycle |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 4 | Code of the violation being reported |
| first_valid_o | output | 1 | A violation has been seen since reset |
| first_code_o | output | 4 | Code of the first violation |
| first_cycle_o | output | TS_W | Cycle number of the first violation |

## Verification
The assertions assume that `cmd_bank` always names an existing bank, which holds when the bank count is a power of two. They also assume that every input has a known value from the first clock after reset. The stimulus drives all inputs on the falling edge and uses only banks 0 to 3. It spaces its commands so that each vector breaks at most the one rule it targets, or else breaks a known set whose lowest code is expected. The maximum-active case runs on a shortened limit so that the open-row window fits in a short run.

// File: rtl/sdtm_pkg.sv
// Shared types and helpers for the SDRAM command timing checker.
// Assumes limits are positive integers in picoseconds.
package sdtm_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_BST = 3'd6,
        OP_RSV = 3'd7
    } sdtm_op_e;

    typedef enum logic [3:0] {
        V_NONE     = 4'd0,
        V_ACT_OPEN = 4'd1,
        V_CLOSED   = 4'd2,
        V_REF_OPEN = 4'd3,
        V_RRD      = 4'd4,
        V_RCD      = 4'd5,
        V_RP       = 4'd6,
        V_RAS_MIN  = 4'd7,
        V_RAS_MAX  = 4'd8,
        V_RC       = 4'd9,
        V_RFC      = 4'd10,
        V_CDL      = 4'd11,
        V_RDL      = 4'd12,
        V_BDL      = 4'd13
    } sdtm_viol_e;

    localparam int NUM_CODES = 14;

    // Round a time up to whole clock cycles.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdtm_age.sv
// Saturating age counter: counts cycles since the last restart pulse.
// Reads 1 in the cycle after a restart; resets to all ones ("long ago").
module sdtm_age #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] age
);

    // Restart to 1, otherwise count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= '1;
        else if (restart)        age <= W'(1);
        else if (age != '1)      age <= age + 1'b1;
    end

endmodule

// File: rtl/sdtm_bank.sv
// Per-bank state: row open flag, age since activate and since precharge,
// and a one-cycle overdue strobe when the row outlives its maximum time.
// Assumes W can hold RAS_MAX_CYC + 2 below saturation.
module sdtm_bank #(
    parameter int W           = 8,
    parameter int RAS_MAX_CYC = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_act,
    input  logic         do_pre,
    output logic         is_open,
    output logic [W-1:0] act_age,
    output logic [W-1:0] pre_age,
    output logic         overdue
);

    localparam logic [W-1:0] OVERDUE_AGE = W'(RAS_MAX_CYC + 1);

    // Row open flag: set by activate, cleared by precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)      is_open <= 1'b0;
        else if (do_act) is_open <= 1'b1;
        else if (do_pre) is_open <= 1'b0;
    end

    sdtm_age #(.W(W)) u_act_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_act),
        .age     (act_age)
    );

    sdtm_age #(.W(W)) u_pre_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_pre),
        .age     (pre_age)
    );

    // Single strobe: the age passes this value exactly once per open row.
    always_comb overdue = is_open && (act_age == OVERDUE_AGE);

endmodule

// File: rtl/sdtm_rules.sv
// Combinational rule evaluation for one command cycle.
// Flags every broken rule and returns the lowest-numbered code.
// Assumes cmd_bank indexes an existing bank.
module sdtm_rules
    import sdtm_pkg::*;
#(
    parameter int NB      = 4,
    parameter int BW      = 2,
    parameter int W       = 8,
    parameter int RRD_C   = 2,
    parameter int RCD_C   = 2,
    parameter int RP_C    = 2,
    parameter int RAS_C   = 4,
    parameter int RC_C    = 6,
    parameter int RFC_C   = 6,
    parameter int CDL_C   = 1,
    parameter int RDL_C   = 2,
    parameter int BDL_C   = 1
) (
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [BW-1:0]         cmd_bank,
    input  logic                  wr_last_beat,
    input  logic [NB-1:0]         bank_open,
    input  logic [NB-1:0][W-1:0]  act_age,
    input  logic [NB-1:0][W-1:0]  pre_age,
    input  logic [NB-1:0]         bank_overdue,
    input  logic [W-1:0]          any_act_age,
    input  logic [W-1:0]          ref_age,
    input  logic [W-1:0]          wr_age,
    output logic [3:0]            code
);

    logic [NUM_CODES-1:1] fl;
    logic [W-1:0]         wr_eff;
    logic                 sel_open;
    logic [W-1:0]         sel_act;
    logic [W-1:0]         sel_pre;
    logic                 pre_short_any;
    logic                 is_cmd;

    // Select the addressed bank and fold the same-cycle write beat in.
    always_comb begin
        wr_eff   = wr_last_beat ? '0 : wr_age;
        sel_open = bank_open[cmd_bank];
        sel_act  = act_age[cmd_bank];
        sel_pre  = pre_age[cmd_bank];
        is_cmd   = cmd_valid && (cmd_op != OP_NOP) && (cmd_op != OP_RSV);
    end

    // Any bank still inside its precharge window.
    always_comb begin
        pre_short_any = 1'b0;
        for (int i = 0; i < NB; i++)
            if (pre_age[i] < W'(RP_C)) pre_short_any = 1'b1;
    end

    // Raise one flag per broken rule for the command in this cycle.
    always_comb begin
        fl = '0;
        fl[V_RAS_MAX] = |bank_overdue;
        if (is_cmd && ref_age < W'(RFC_C)) fl[V_RFC] = 1'b1;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_ACT: begin
                    fl[V_ACT_OPEN] = sel_open;
                    fl[V_RRD]      = any_act_age < W'(RRD_C);
                    fl[V_RP]       = sel_pre < W'(RP_C);
                    fl[V_RC]       = sel_act < W'(RC_C);
                end
                OP_RD, OP_WR: begin
                    fl[V_CLOSED] = !sel_open;
                    fl[V_RCD]    = sel_act < W'(RCD_C);
                    fl[V_CDL]    = wr_eff < W'(CDL_C);
                end
                OP_PRE: begin
                    fl[V_CLOSED]  = !sel_open;
                    fl[V_RAS_MIN] = sel_act < W'(RAS_C);
                    fl[V_RDL]     = wr_eff < W'(RDL_C);
                end
                OP_REF: begin
                    fl[V_REF_OPEN] = |bank_open;
                    fl[V_RP]       = pre_short_any;
                end
                OP_BST: fl[V_BDL] = wr_eff < W'(BDL_C);
                default: ;
            endcase
        end
    end

    // Priority pick: the lowest set code wins.
    always_comb begin
        code = V_NONE;
        for (int i = NUM_CODES - 1; i >= 1; i--)
            if (fl[i]) code = 4'(i);
    end

endmodule

// File: rtl/sdtm_mon.sv
// SDRAM command timing checker, top level.
// Converts picosecond limits to cycles, tracks bank state and ages,
// registers a one-cycle violation report and latches the first failure.
// Assumes NUM_BANKS is a power of two and at least 2.
module sdtm_mon
    import sdtm_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int TS_W         = 32,
    parameter int CLK_PS       = 10000,
    parameter int T_RRD_PS     = 12000,
    parameter int T_RCD_PS     = 18000,
    parameter int T_RP_PS      = 18000,
    parameter int T_RAS_PS     = 40000,
    parameter int T_RAS_MAX_PS = 100_000_000,
    parameter int T_RC_PS      = 58000,
    parameter int T_RFC_PS     = 60000,
    parameter int CDL_CYC      = 1,
    parameter int RDL_CYC      = 2,
    parameter int BDL_CYC      = 1,
    localparam int BW          = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [BW-1:0]   cmd_bank,
    input  logic            wr_last_beat,
    output logic            viol_o,
    output logic [3:0]      viol_code_o,
    output logic            first_valid_o,
    output logic [3:0]      first_code_o,
    output logic [TS_W-1:0] first_cycle_o
);

    localparam int RRD_C   = ps_to_cyc(T_RRD_PS, CLK_PS);
    localparam int RCD_C   = ps_to_cyc(T_RCD_PS, CLK_PS);
    localparam int RP_C    = ps_to_cyc(T_RP_PS, CLK_PS);
    localparam int RAS_C   = ps_to_cyc(T_RAS_PS, CLK_PS);
    localparam int RASX_C  = ps_to_cyc(T_RAS_MAX_PS, CLK_PS);
    localparam int RC_C    = ps_to_cyc(T_RC_PS, CLK_PS);
    localparam int RFC_C   = ps_to_cyc(T_RFC_PS, CLK_PS);
    localparam int MAX_C   = imax(imax(RASX_C, imax(RC_C, RFC_C)),
                                  imax(RDL_CYC, imax(CDL_CYC, BDL_CYC)));
    localparam int W       = $clog2(MAX_C + 3);

    logic [NUM_BANKS-1:0]         act_hit;
    logic [NUM_BANKS-1:0]         pre_hit;
    logic [NUM_BANKS-1:0]         bank_open;
    logic [NUM_BANKS-1:0]         bank_overdue;
    logic [NUM_BANKS-1:0][W-1:0]  act_age;
    logic [NUM_BANKS-1:0][W-1:0]  pre_age;
    logic [W-1:0]                 any_act_age;
    logic [W-1:0]                 ref_age;
    logic [W-1:0]                 wr_age;
    logic [3:0]                   code_n;
    logic [TS_W-1:0]              cyc;
    logic                         is_act;
    logic                         is_ref;

    // Decode the command kinds that restart the global age counters.
    always_comb begin
        is_act = cmd_valid && (cmd_op == OP_ACT);
        is_ref = cmd_valid && (cmd_op == OP_REF);
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign act_hit[g] = is_act && (cmd_bank == BW'(g));
        assign pre_hit[g] = cmd_valid && (cmd_op == OP_PRE) && (cmd_bank == BW'(g));

        sdtm_bank #(.W(W), .RAS_MAX_CYC(RASX_C)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .do_act  (act_hit[g]),
            .do_pre  (pre_hit[g]),
            .is_open (bank_open[g]),
            .act_age (act_age[g]),
            .pre_age (pre_age[g]),
            .overdue (bank_overdue[g])
        );
    end

    sdtm_age #(.W(W)) u_any_act (
        .clk(clk), .rst_n(rst_n), .restart(is_act), .age(any_act_age)
    );

    sdtm_age #(.W(W)) u_ref (
        .clk(clk), .rst_n(rst_n), .restart(is_ref), .age(ref_age)
    );

    sdtm_age #(.W(W)) u_wr (
        .clk(clk), .rst_n(rst_n), .restart(wr_last_beat), .age(wr_age)
    );

    sdtm_rules #(
        .NB(NUM_BANKS), .BW(BW), .W(W),
        .RRD_C(RRD_C), .RCD_C(RCD_C), .RP_C(RP_C), .RAS_C(RAS_C),
        .RC_C(RC_C), .RFC_C(RFC_C),
        .CDL_C(CDL_CYC), .RDL_C(RDL_CYC), .BDL_C(BDL_CYC)
    ) u_rules (
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .wr_last_beat (wr_last_beat),
        .bank_open    (bank_open),
        .act_age      (act_age),
        .pre_age      (pre_age),
        .bank_overdue (bank_overdue),
        .any_act_age  (any_act_age),
        .ref_age      (ref_age),
        .wr_age       (wr_age),
        .code         (code_n)
    );

    // Free-running cycle number used to stamp the first failure.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    // One-cycle violation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o      <= 1'b0;
            viol_code_o <= V_NONE;
        end else begin
            viol_o      <= (code_n != V_NONE);
            viol_code_o <= code_n;
        end
    end

    // Sticky record of the first violation since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_valid_o <= 1'b0;
            first_code_o  <= V_NONE;
            first_cycle_o <= '0;
        end else if (!first_valid_o && code_n != V_NONE) begin
            first_valid_o <= 1'b1;
            first_code_o  <= code_n;
            first_cycle_o <= cyc;
        end
    end

endmodule

// File: rtl/sdtm_chk.sv
// Property checker for sdtm_mon, attached by bind below.
// Relates the command inputs and bank state to the registered reports.
module sdtm_chk #(
    parameter int NB   = 4,
    parameter int BW   = 2,
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic [BW-1:0]   cmd_bank,
    input logic [NB-1:0]   bank_open,
    input logic [NB-1:0]   bank_overdue,
    input logic            viol_o,
    input logic [3:0]      viol_code_o,
    input logic            first_valid_o,
    input logic [3:0]      first_code_o,
    input logic [TS_W-1:0] first_cycle_o
);

    logic real_cmd;
    always_comb real_cmd = cmd_valid && cmd_op != 3'd0 && cmd_op != 3'd7;

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!real_cmd && bank_overdue == '0) |=> !viol_o);

    assert_act_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && bank_open[cmd_bank])
        |=> (viol_o && viol_code_o == 4'd1));

    assert_closed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4)
         && !bank_open[cmd_bank])
        |=> (viol_o && viol_code_o == 4'd2));

    assert_ref_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5 && |bank_open) |=> (viol_code_o == 4'd3));

    assert_overdue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_overdue && !real_cmd) |=> (viol_o && viol_code_o == 4'd8));

    assert_first_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid_o |=> (first_valid_o && $stable(first_code_o)
                           && $stable(first_cycle_o)));

    assert_first_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_valid_o) |-> (viol_o && first_code_o == viol_code_o));

endmodule

bind sdtm_mon sdtm_chk #(.NB(NUM_BANKS), .BW(BW), .TS_W(TS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_bank      (cmd_bank),
    .bank_open     (bank_open),
    .bank_overdue  (bank_overdue),
    .viol_o        (viol_o),
    .viol_code_o   (viol_code_o),
    .first_valid_o (first_valid_o),
    .first_code_o  (first_code_o),
    .first_cycle_o (first_cycle_o)
);

// File: tb/tb_sdtm_mon.sv
`timescale 1ns/1ps
module tb_sdtm_mon;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic        wr_last_beat = 1'b0;
    logic        viol_o;
    logic [3:0]  viol_code_o;
    logic        first_valid_o;
    logic [3:0]  first_code_o;
    logic [31:0] first_cycle_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Shortened maximum active time: 300 ns = 30 cycles.
    sdtm_mon #(.T_RAS_MAX_PS(300_000)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .wr_last_beat(wr_last_beat),
        .viol_o(viol_o), .viol_code_o(viol_code_o),
        .first_valid_o(first_valid_o), .first_code_o(first_code_o),
        .first_cycle_o(first_cycle_o)
    );

    // {valid, op[2:0], bank[1:0], wr_last, exp_viol, exp_code[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},   // 0 idle
        {1'b1,3'd5,2'd0,1'b0,1'b0,4'd0},   // 1 refresh
        {1'b1,3'd1,2'd0,1'b0,1'b1,4'd10},  // 2 act b0 too soon after refresh
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b1,3'd1,2'd1,1'b0,1'b0,4'd0},   // 7 act b1
        {1'b1,3'd2,2'd1,1'b0,1'b1,4'd5},   // 8 read b1 one cycle after act
        {1'b1,3'd2,2'd1,1'b0,1'b0,4'd0},   // 9 read b1 at limit
        {1'b1,3'd3,2'd0,1'b0,1'b0,4'd0},   // 10 write b0
        {1'b0,3'd0,2'd0,1'b1,1'b0,4'd0},   // 11 last write beat
        {1'b1,3'd4,2'd0,1'b0,1'b1,4'd12},  // 12 precharge b0 one after beat
        {1'b1,3'd1,2'd0,1'b0,1'b1,4'd6},   // 13 act b0 one after precharge
        {1'b1,3'd1,2'd2,1'b0,1'b1,4'd4},   // 14 act b2 one after act b0
        {1'b1,3'd4,2'd2,1'b0,1'b1,4'd7},   // 15 precharge b2 too early
        {1'b1,3'd1,2'd2,1'b0,1'b1,4'd6},   // 16 act b2: precharge beats cycle rule
        {1'b1,3'd3,2'd3,1'b0,1'b1,4'd2},   // 17 write closed b3
        {1'b1,3'd1,2'd1,1'b0,1'b1,4'd1},   // 18 act open b1
        {1'b1,3'd5,2'd0,1'b0,1'b1,4'd3},   // 19 refresh with banks open
        {1'b1,3'd2,2'd0,1'b0,1'b1,4'd10},  // 20 read inside refresh cycle
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b1,3'd6,2'd0,1'b1,1'b1,4'd13},  // 25 burst stop on last beat
        {1'b1,3'd2,2'd0,1'b1,1'b1,4'd11},  // 26 read on last beat
        {1'b1,3'd2,2'd0,1'b0,1'b0,4'd0},   // 27 read one after beat
        {1'b1,3'd6,2'd0,1'b0,1'b0,4'd0},   // 28 burst stop
        {1'b1,3'd4,2'd3,1'b0,1'b1,4'd2},   // 29 precharge closed b3
        {1'b1,3'd4,2'd0,1'b0,1'b0,4'd0},   // 30 precharge b0
        {1'b1,3'd4,2'd1,1'b0,1'b0,4'd0},   // 31 precharge b1
        {1'b1,3'd4,2'd2,1'b0,1'b0,4'd0},   // 32 precharge b2
        {1'b1,3'd5,2'd0,1'b0,1'b1,4'd6},   // 33 refresh one after precharge
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0},
        {1'b1,3'd5,2'd0,1'b0,1'b0,4'd0}    // 39 refresh at limit
    };

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1, 4'd2:          return "R4";
            4'd3:                return "R5";
            4'd4, 4'd9:          return "R6";
            4'd5:                return "R7";
            4'd6:                return "R8";
            4'd7:                return "R9";
            4'd8:                return "R10";
            4'd10:               return "R11";
            4'd11, 4'd12, 4'd13: return "R12";
            default:             return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, then check the registered report after the edge.
    task automatic step(input logic v, input logic [2:0] op, input logic [1:0] b,
                        input logic wl, input logic ev, input logic [3:0] ec,
                        input string tag);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_bank = b; wr_last_beat = wl;
        @(posedge clk);
        #1;
        check(viol_o == ev && viol_code_o == (ev ? ec : 4'd0), tag, "viol/code",
              {viol_o, viol_code_o}, {ev, ev ? ec : 4'd0});
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R14: reset state
        check(viol_o == 1'b0 && viol_code_o == 4'd0, "R14", "report in reset",
              {viol_o, viol_code_o}, 0);
        check(first_valid_o == 1'b0, "R14", "first flag in reset", first_valid_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            step(v[11], v[10:8], v[7:6], v[5], v[4], v[3:0], tag_of(v[3:0]));
        end

        // R2: reserved opcode is ignored
        step(1'b1, 3'd7, 2'd3, 1'b0, 1'b0, 4'd0, "R2");
        // R13: first failure was table entry 2, i.e. cycle 3 after release
        check(first_valid_o == 1'b1, "R13", "first flag", first_valid_o, 1);
        check(first_code_o == 4'd10, "R13", "first code", first_code_o, 10);
        check(first_cycle_o == 32'd3, "R13", "first cycle", first_cycle_o, 3);

        repeat (5) idle("R11");
        // R10: open b3 and let it exceed 30 cycles
        step(1'b1, 3'd1, 2'd3, 1'b0, 1'b0, 4'd0, "R10");
        for (int k = 1; k <= 32; k++)
            step(1'b0, 3'd0, 2'd0, 1'b0, (k == 31), 4'd8, "R10");
        step(1'b1, 3'd4, 2'd3, 1'b0, 1'b0, 4'd0, "R10");
        idle("R8");
        idle("R8");
        step(1'b1, 3'd1, 2'd3, 1'b0, 1'b0, 4'd0, "R8");
        idle("R9");
        idle("R9");
        step(1'b1, 3'd4, 2'd3, 1'b0, 1'b1, 4'd7, "R9");
        idle("R1");
        // R1: 58 ns rounds up to 6 cycles, so 5 cycles is flagged
        step(1'b1, 3'd1, 2'd3, 1'b0, 1'b1, 4'd9, "R1");
        idle("R6");
        step(1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 4'd0, "R6");
        check(first_code_o == 4'd10 && first_cycle_o == 32'd3, "R13",
              "first record held", first_code_o, 10);

        // R14: reset mid-run closes banks and clears the record
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; wr_last_beat = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(viol_o == 1'b0 && first_valid_o == 1'b0 && first_code_o == 4'd0,
              "R14", "outputs after reset", {viol_o, first_valid_o, first_code_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 3'd2, 2'd0, 1'b0, 1'b1, 4'd2, "R14");
        check(first_cycle_o == 32'd1 && first_code_o == 4'd2, "R13",
              "first cycle after reset", first_cycle_o, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule